// File: doc/BRIEF.md
# Sector ECC Syndrome Corrector

This block takes the three parity bytes read back from a flash spare area and the three parity bytes computed over the 512-byte sector just read, and decides what happened to the sector. It XORs the two sets into a 24-bit syndrome. It then sorts the result into one of four outcomes: the data is clean, one data bit is wrong and can be repaired, the damage lies in the stored parity itself, or the sector is beyond repair.

When a single data bit is at fault, the block works out the byte index and the bit index from the syndrome. It repairs the byte in place through a synchronous sector-buffer port: one read, then one write of the byte with the faulty bit inverted. A sector whose stored parity is all ones can be treated as a page that never had parity programmed, under control of an input pin. A one-cycle `start` begins a job, and a one-cycle `done` ends it with a two-bit status.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: The syndrome is `par_stored ^ par_calc`, with syndrome byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. An all-zero syndrome gives status 0 (clean), and the buffer port is not touched.
- R2: When `par_stored` is 24'hFFFFFF and `ignore_unset` is high, the status is 0 and the buffer is not touched. With `ignore_unset` low, the same inputs are classified by the other rules.
- R3: A nonzero syndrome is correctable when, in each of the three syndrome bytes, every bit pair (1,0), (3,2), (5,4), (7,6) holds two different values. A correctable syndrome gives status 1.
- R4: For status 1, `err_byte` is {s2[1], s1[7], s1[5], s1[3], s1[1], s0[7], s0[5], s0[3], s0[1]}, where sN is syndrome byte N. For any other status, `err_byte` is 0.
- R5: For status 1, `err_bit` is {s2[7], s2[5], s2[3]}. For any other status, `err_bit` is 0.
- R6: A correction reads `buf_addr = err_byte` one cycle after `start`. `RD_LAT` cycles later, it writes the read byte XOR (1 << `err_bit`) to the same address. No other buffer access takes place.
- R7: A syndrome with exactly one bit set gives status 2 (parity-field error), and the buffer is not touched.
- R8: Every other nonzero syndrome gives status 3 (uncorrectable), and the buffer is not touched.
- R9: `done` is high for exactly one cycle: 2 cycles after `start` without a correction, and 2+`RD_LAT` cycles after `start` with one. `status`, `err_byte` and `err_bit` then hold until the next job.
- R10: `busy` is high from the cycle after an accepted `start` until the `done` cycle, inclusive. A `start` raised while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `buf_en`, `status`, `err_byte` and `err_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; the parity inputs are sampled in the same cycle |
| ignore_unset | input | 1 | Treat all-ones stored parity as an unprogrammed page |
| par_stored | input | 24 | Parity bytes read from flash |
| par_calc | input | 24 | Parity bytes computed over the sector |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 parity error, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the repaired bit |
| err_bit | output | 3 | Bit index of the repaired bit |
| buf_en | output | 1 | Sector buffer access strobe |
| buf_we | output | 1 | Buffer write (1) or read (0) |
| buf_addr | output | 9 | Buffer byte address |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Buffer read data, valid `RD_LAT` cycles after a read |

## Verification
A job that repairs nothing raises `done` two cycles after `start`. A repair puts a read on the buffer port one cycle after `start`, a write `RD_LAT` cycles after that, and `done` one cycle later. The reference model in the bench counts cycles from the accepted `start` and compares the buffer strobes, address, write data, `busy` and `done` on every falling edge against the cycle in which each is due. The held `status` and index outputs are compared only once a job has ended, because R9 makes them valid from that point until the next job.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN  = 2'd0,
      ST_FIXED  = 2'd1,
      ST_PARITY = 2'd2,
      ST_FATAL  = 2'd3
   } ecc_status_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHECK,
      S_WAIT,
      S_WRITE,
      S_FIN
   } ctl_state_e;

endpackage

// File: rtl/ecc_syn_capture.sv
module ecc_syn_capture #(
   parameter int DATA_W = 8,
   parameter int NBYTES = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [NBYTES*DATA_W-1:0] stored,
   input  logic [NBYTES*DATA_W-1:0] calc,
   input  logic                     ignore_unset,
   output logic [NBYTES*DATA_W-1:0] syn_q,
   output logic                     unset_q,
   output logic                     ign_q
);
   logic [NBYTES*DATA_W-1:0] syn_d;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign syn_d[g*DATA_W +: DATA_W] = stored[g*DATA_W +: DATA_W] ^ calc[g*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syn_q   <= '0;
         unset_q <= 1'b0;
         ign_q   <= 1'b0;
      end else if (load) begin
         syn_q   <= syn_d;
         unset_q <= &stored;
         ign_q   <= ignore_unset;
      end
   end
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
   import ecc_fix_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 9,
   parameter int BIT_W  = 3
) (
   input  logic [3*DATA_W-1:0] syn,
   input  logic                unset,
   input  logic                ign,
   output ecc_status_e         verdict,
   output logic [ADDR_W-1:0]   byte_idx,
   output logic [BIT_W-1:0]    bit_idx
);
   localparam int HALF = DATA_W / 2;

   function automatic logic [DATA_W-1:0] even_mask();
      logic [DATA_W-1:0] m;
      for (int i = 0; i < DATA_W; i++) m[i] = (i % 2 == 0);
      return m;
   endfunction

   localparam logic [DATA_W-1:0] EMASK = even_mask();

   logic [2:0] pair_ok;
   logic       single;

   for (genvar g = 0; g < 3; g++) begin : g_pair
      logic [DATA_W-1:0] d;
      assign d          = syn[g*DATA_W +: DATA_W];
      assign pair_ok[g] = (((d ^ (d >> 1)) & EMASK) == EMASK);
   end

   assign single = ($countones(syn) == 1);

   for (genvar i = 0; i < HALF; i++) begin : g_lo_idx
      assign byte_idx[i]        = syn[2*i + 1];
      assign byte_idx[HALF + i] = syn[DATA_W + 2*i + 1];
   end
   assign byte_idx[ADDR_W-1] = syn[2*DATA_W + 1];

   for (genvar i = 0; i < BIT_W; i++) begin : g_bit_idx
      assign bit_idx[i] = syn[2*DATA_W + 2*i + 3];
   end

   always_comb begin
      if (syn == '0)          verdict = ST_CLEAN;
      else if (unset && ign)  verdict = ST_CLEAN;
      else if (&pair_ok)      verdict = ST_FIXED;
      else if (single)        verdict = ST_PARITY;
      else                    verdict = ST_FATAL;
   end
endmodule

// File: rtl/ecc_patch_ctrl.sv
module ecc_patch_ctrl
   import ecc_fix_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 9,
   parameter int BIT_W  = 3,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  ecc_status_e       verdict,
   input  logic [ADDR_W-1:0] byte_idx,
   input  logic [BIT_W-1:0]  bit_idx,
   output logic              load,
   output logic              busy,
   output logic              done,
   output ecc_status_e       status,
   output logic [ADDR_W-1:0] err_byte,
   output logic [BIT_W-1:0]  err_bit,
   output logic              buf_en,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_wdata,
   input  logic [DATA_W-1:0] buf_rdata
);
   localparam int CNT_W = $clog2(RD_LAT + 1);

   ctl_state_e        state;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cnt      <= '0;
         status   <= ST_CLEAN;
         err_byte <= '0;
         err_bit  <= '0;
      end else begin
         case (state)
            S_IDLE:  if (start) state <= S_CHECK;
            S_CHECK: begin
               status <= verdict;
               if (verdict == ST_FIXED) begin
                  err_byte <= byte_idx;
                  err_bit  <= bit_idx;
                  cnt      <= CNT_W'(1);
                  state    <= (RD_LAT == 1) ? S_WRITE : S_WAIT;
               end else begin
                  err_byte <= '0;
                  err_bit  <= '0;
                  state    <= S_FIN;
               end
            end
            S_WAIT: begin
               if (cnt == CNT_W'(RD_LAT - 1)) state <= S_WRITE;
               else                           cnt   <= cnt + CNT_W'(1);
            end
            S_WRITE: state <= S_FIN;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign load      = (state == S_IDLE) && start;
   assign busy      = (state != S_IDLE);
   assign done      = (state == S_FIN);
   assign buf_en    = ((state == S_CHECK) && (verdict == ST_FIXED)) || (state == S_WRITE);
   assign buf_we    = (state == S_WRITE);
   assign buf_addr  = (state == S_CHECK) ? byte_idx : err_byte;
   assign buf_wdata = buf_rdata ^ (DATA_W'(1) << err_bit);

   // R9: done never lasts two cycles
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: results stay put between jobs
   assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

   // R6: exactly one write per repair
   assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en && buf_we) |=> !(buf_en && buf_we));

   // R6: buffer is quiet outside a job
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !buf_en);

   // R10: a job always ends with busy low after done
   assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
   import ecc_fix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int DATA_W       = 8,
   parameter int RD_LAT       = 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic                             ignore_unset,
   input  logic [3*DATA_W-1:0]              par_stored,
   input  logic [3*DATA_W-1:0]              par_calc,
   output logic                             busy,
   output logic                             done,
   output logic [1:0]                       status,
   output logic [$clog2(SECTOR_BYTES)-1:0]  err_byte,
   output logic [$clog2(DATA_W)-1:0]        err_bit,
   output logic                             buf_en,
   output logic                             buf_we,
   output logic [$clog2(SECTOR_BYTES)-1:0]  buf_addr,
   output logic [DATA_W-1:0]                buf_wdata,
   input  logic [DATA_W-1:0]                buf_rdata
);
   localparam int ADDR_W = $clog2(SECTOR_BYTES);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int SYN_W  = 3 * DATA_W;

   if (DATA_W != 8) begin : g_bad_width
      $error("ecc_syndrome_fixer: the syndrome map needs DATA_W of 8");
   end
   if (ADDR_W != 9) begin : g_bad_sector
      $error("ecc_syndrome_fixer: the syndrome map needs a 512-byte sector");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("ecc_syndrome_fixer: RD_LAT must be at least 1");
   end

   logic [SYN_W-1:0]  syn_q;
   logic              unset_q, ign_q, load;
   ecc_status_e       verdict, status_e;
   logic [ADDR_W-1:0] byte_idx;
   logic [BIT_W-1:0]  bit_idx;

   ecc_syn_capture #(.DATA_W(DATA_W), .NBYTES(3)) u_cap (
      .clk(clk), .rst_n(rst_n), .load(load),
      .stored(par_stored), .calc(par_calc), .ignore_unset(ignore_unset),
      .syn_q(syn_q), .unset_q(unset_q), .ign_q(ign_q)
   );

   ecc_syn_classify #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_cls (
      .syn(syn_q), .unset(unset_q), .ign(ign_q),
      .verdict(verdict), .byte_idx(byte_idx), .bit_idx(bit_idx)
   );

   ecc_patch_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W), .RD_LAT(RD_LAT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .verdict(verdict), .byte_idx(byte_idx), .bit_idx(bit_idx),
      .load(load), .busy(busy), .done(done), .status(status_e),
      .err_byte(err_byte), .err_bit(err_bit),
      .buf_en(buf_en), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
   );

   assign status = status_e;

   // R4 R5: indices are only reported for a repair
   assert_index_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 2'd1) |-> (err_byte == '0 && err_bit == '0));

   // R7 R8: no buffer write when the job ends in a non-repair status
   assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 2'd1) |-> !$past(buf_we && buf_en));
endmodule

// File: tb/tb_ecc_syndrome_fixer.sv
module tb_ecc_syndrome_fixer;
   localparam int RD_LAT = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ignore_unset = 1'b0;
   logic [23:0] par_stored = '0, par_calc = '0;
   logic        busy, done, buf_en, buf_we;
   logic [1:0]  status;
   logic [8:0]  err_byte, buf_addr;
   logic [2:0]  err_bit;
   logic [7:0]  buf_wdata;
   logic [7:0]  buf_rdata = '0;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   ecc_syndrome_fixer #(.SECTOR_BYTES(512), .DATA_W(8), .RD_LAT(RD_LAT)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ignore_unset(ignore_unset),
      .par_stored(par_stored), .par_calc(par_calc),
      .busy(busy), .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
      .buf_en(buf_en), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
   );

   // sector buffer with one cycle of read latency
   logic [7:0] mem [512];
   logic [7:0] gold [512];
   always @(posedge clk) begin
      if (buf_en && buf_we) mem[buf_addr] <= buf_wdata;
      if (buf_en && !buf_we) buf_rdata <= mem[buf_addr];
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void classify(input logic [23:0] st, input logic [23:0] ca, input bit ign,
                                    output int cls, output int b, output int k, output string tag);
      logic [23:0] s;
      bit ok;
      int ones;
      s = st ^ ca;
      ok = 1;
      ones = 0;
      for (int p = 0; p < 12; p++) if (s[2*p] == s[2*p+1]) ok = 0;
      for (int i = 0; i < 24; i++) ones += int'(s[i]);
      b = 0; k = 0;
      if (s == 0)                        begin cls = 0; tag = "R1"; end
      else if (st == 24'hFFFFFF && ign)  begin cls = 0; tag = "R2"; end
      else if (ok) begin
         cls = 1; tag = "R3";
         b = int'({s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]});
         k = int'({s[23], s[21], s[19]});
      end
      else if (ones == 1)                begin cls = 2; tag = "R7"; end
      else                               begin cls = 3; tag = "R8"; end
   endfunction

   function automatic logic [23:0] make_syn(input int b, input int k);
      logic [11:0] a;
      logic [23:0] s;
      a = {k[2:0], b[8:0]};
      for (int p = 0; p < 12; p++) begin
         s[2*p+1] = a[p];
         s[2*p]   = ~a[p];
      end
      return s;
   endfunction

   // reference model, advanced on every falling edge
   bit    m_busy = 0, m_fix = 0;
   int    m_cnt = 0, m_done_at = 0, m_byte = 0, m_bit = 0, m_cls = 0;
   int    h_status = 0, h_byte = 0, h_bit = 0;
   string m_tag = "R1";

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit was, e_en, e_we, e_done;
         int e_addr, e_wdata;
         was = m_busy;
         e_en = 0; e_we = 0; e_done = 0; e_addr = 0; e_wdata = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_fix && m_cnt == 1) begin e_en = 1; e_addr = m_byte; end
            if (m_fix && m_cnt == 1 + RD_LAT) begin
               e_en = 1; e_we = 1; e_addr = m_byte;
               e_wdata = int'(gold[m_byte] ^ (8'd1 << m_bit));
            end
            if (m_cnt == m_done_at) begin
               e_done = 1; m_busy = 0;
               h_status = m_cls; h_byte = m_byte; h_bit = m_bit;
            end
         end
         chk(done == e_done, "R9 done timing", int'(done), int'(e_done));
         chk(busy == was, "R10 busy", int'(busy), int'(was));
         chk(buf_en == e_en, m_fix ? "R6 buffer strobe" : {m_tag, " buffer untouched"}, int'(buf_en), int'(e_en));
         if (e_en) begin
            chk(buf_we == e_we, "R6 read/write order", int'(buf_we), int'(e_we));
            chk(int'(buf_addr) == e_addr, "R4 buffer address", int'(buf_addr), e_addr);
         end
         if (e_we) begin
            chk(int'(buf_wdata) == e_wdata, "R5 repaired byte", int'(buf_wdata), e_wdata);
            gold[m_byte] = buf_wdata ^ 8'h00;
            gold[m_byte] = 8'(e_wdata);
         end
         if (!m_busy) begin
            chk(int'(status) == h_status, {m_tag, " status"}, int'(status), h_status);
            chk(int'(err_byte) == h_byte, "R4 err_byte", int'(err_byte), h_byte);
            chk(int'(err_bit) == h_bit, "R5 err_bit", int'(err_bit), h_bit);
         end
         if (!was && start) begin
            classify(par_stored, par_calc, ignore_unset, m_cls, m_byte, m_bit, m_tag);
            m_busy = 1; m_cnt = 0;
            m_fix = (m_cls == 1);
            m_done_at = m_fix ? 2 + RD_LAT : 2;
         end
      end
   end

   task automatic run(input logic [23:0] st, input logic [23:0] ca, input bit ign, input bit poke);
      @(posedge clk); #1;
      par_stored = st; par_calc = ca; ignore_unset = ign; start = 1;
      @(posedge clk); #1;
      start = 0;
      par_stored = ~st;               // inputs change after sampling
      if (poke) begin                 // R10: start while busy must be ignored
         @(posedge clk); #1; start = 1;
         @(posedge clk); #1; start = 0;
      end
      repeat (6) @(posedge clk);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) begin
         mem[i]  = 8'(i * 37 + 5);
         gold[i] = 8'(i * 37 + 5);
      end
      repeat (2) @(negedge clk);
      // R11: reset state
      chk(busy == 0 && done == 0 && buf_en == 0, "R11 reset controls", int'({busy, done, buf_en}), 0);
      chk(status == 0 && err_byte == 0 && err_bit == 0, "R11 reset results",
          int'({status, err_byte, err_bit}), 0);
      @(posedge clk); #1; rst_n = 1;
      repeat (2) @(posedge clk);

      run(24'h123456, 24'h123456, 0, 0);                        // R1
      run(24'hFFFFFF, 24'h00A5C3, 1, 0);                        // R2 bypass
      run(24'hFFFFFF, 24'h00A5C3, 0, 0);                        // R2 without bypass
      run(24'h3C0F11 ^ make_syn(0, 0),   24'h3C0F11, 0, 0);      // R3 R4 R5
      run(24'h5A5A5A ^ make_syn(511, 7), 24'h5A5A5A, 0, 0);
      run(24'hC0FFEE ^ make_syn(9'h155, 2), 24'hC0FFEE, 0, 0);
      run(24'h0BADF0 ^ make_syn(9'h0AA, 5), 24'h0BADF0, 0, 1);   // R10 poke
      run(24'h0BADF0 ^ make_syn(9'h0AA, 5), 24'h0BADF0, 0, 0);   // R6 repeat restores
      run(24'h001234 ^ 24'h002000, 24'h001234, 0, 0);            // R7
      run(24'h800000, 24'h000000, 0, 0);                         // R7 top bit
      run(24'h000003, 24'h000000, 0, 0);                         // R8
      run(24'hFFFFFF, 24'hFFFFFE, 0, 0);                         // R7 near erased
      repeat (4) @(posedge clk);
      #2;
      for (int i = 0; i < 512; i++)                              // R6 buffer contents
         chk(mem[i] == gold[i], "R6 final buffer", int'(mem[i]), int'(gold[i]));
      chk(mem[0] == 8'(5 ^ 1), "R6 byte 0 bit 0", int'(mem[0]), int'(8'(5 ^ 1)));
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule